// File: doc/BRIEF.md
# Dual-clock FIFO with ring-buffer pointer crossing

This block is a first-in-first-out queue between two clock domains that run at the same frequency but with an unknown, fixed phase relation. The producer pushes words on its own clock and sees a full flag. The consumer sees the oldest stored word on its data output and pops it on its own clock. It also sees an empty flag.

The pointers do not cross through Gray-code synchronizers. Each domain sends its binary pointer to the other domain through a small side ring buffer. The side ring buffer is written on every cycle of the source clock and read on every cycle of the destination clock, with an index offset fixed at reset. Each flag is computed in its own domain from the local pointer and the delayed copy of the remote pointer. Both flags are therefore conservative. Each pointer carries one bit beyond the address, so the full and empty cases can be told apart when the address bits are equal.

Top module: `lockstep_fifo`

## Requirements
- R1: While rst_ni is low and after it is released, empty_o is 1 and full_o is 0 until a word is written.
- R2: A word on wr_data_i is accepted at a rising edge of wr_clk_i when wr_en_i is 1 and full_o is 0 at that edge.
- R3: Accepted words leave the read port in the order in which they were written, with no loss and no duplication.
- R4: A write attempted while full_o is 1 is ignored. After 20 write attempts into an empty FIFO of depth 16 with no reads, exactly the first 16 words are read back.
- R5: A read attempted while empty_o is 1 is ignored. Later writes are read back correctly, and empty_o stays 1 until a word is written.
- R6: The read port shows the oldest word on rd_data_o whenever empty_o is 0, without any read being requested (first word fall through).
- R7: full_o is 1 in the write cycle that follows the edge accepting the DEPTH-th unread word. empty_o is 1 in the read cycle that follows the edge popping the last word.
- R8: After a write into an empty FIFO, empty_o goes to 0 within 4 read-clock cycles. After a read from a full FIFO, full_o goes to 0 within 4 write-clock cycles.
- R9: Writes and reads running at the same time on the two phase-shifted clocks keep the order and content of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write-domain clock |
| rd_clk_i | input | 1 | Read-domain clock, same frequency as wr_clk_i |
| rst_ni | input | 1 | Asynchronous reset for both domains, active low |
| wr_en_i | input | 1 | Write request, valid with wr_data_i |
| wr_data_i | input | WIDTH | Word to store |
| full_o | output | 1 | No free entry, from the write side's view |
| rd_en_i | input | 1 | Pop the word shown on rd_data_o |
| rd_data_o | output | WIDTH | Oldest stored word, valid while empty_o is 0 |
| empty_o | output | 1 | No stored word, from the read side's view |

## Verification
Some results depend only on local state and are due in the very next cycle of their own clock. These are the rise of full_o after the accepting write edge, the rise of empty_o after the final pop, and the ignored writes and reads. The bench samples these on the falling edge right after that rising edge. The crossing results travel through a pointer register, a ring slot and the destination's output register, so they are due within 4 destination cycles. The bench counts destination cycles up to that bound, and it waits 8 cycles before checking settled flags after each stimulus step. Read data is compared against a bench-side queue on every falling read edge where empty_o is 0, and the clocks are offset by a quarter period.

// File: rtl/lockstep_fifo_pkg.sv
package lockstep_fifo_pkg;
  // side ring: depth and reset offset between its write and read index
  localparam int unsigned RING_DEPTH = 4;
  localparam int unsigned RING_OFS   = 2;
endpackage

// File: rtl/ptr_ring.sv
module ptr_ring #(
  parameter int unsigned W     = 5,
  parameter int unsigned DEPTH = lockstep_fifo_pkg::RING_DEPTH,
  parameter int unsigned OFS   = lockstep_fifo_pkg::RING_OFS
) (
  input  logic         src_clk_i,
  input  logic         dst_clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned IW = $clog2(DEPTH);

  logic [W-1:0]  slot_q [DEPTH];
  logic [IW-1:0] widx_q, ridx_q;

  // written every source cycle
  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      widx_q <= IW'(OFS);
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      slot_q[widx_q] <= d_i;
      widx_q         <= widx_q + 1'b1;
    end
  end

  // read every destination cycle, lagging by OFS slots
  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ridx_q <= '0;
      q_o    <= '0;
    end else begin
      q_o    <= slot_q[ridx_q];
      ridx_q <= ridx_q + 1'b1;
    end
  end
endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rd_ptr_s_i,
  output logic [PW-1:0] wr_ptr_o,
  output logic          push_o,
  output logic          full_o
);
  logic [PW-1:0] occ;

  assign occ    = wr_ptr_o - rd_ptr_s_i;
  assign full_o = occ[PW-1];
  assign push_o = wr_en_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_ptr_o <= '0;
    else if (push_o) wr_ptr_o <= wr_ptr_o + 1'b1;
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> wr_ptr_o == $past(wr_ptr_o));
  // R4
  wr_occ_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ptr_o - rd_ptr_s_i) <= PW'(DEPTH));
  // R2
  wr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> wr_ptr_o == $past(wr_ptr_o));
endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [PW-1:0] wr_ptr_s_i,
  output logic [PW-1:0] rd_ptr_o,
  output logic          empty_o
);
  assign empty_o = (rd_ptr_o == wr_ptr_s_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_ptr_o <= '0;
    else if (rd_en_i && !empty_o) rd_ptr_o <= rd_ptr_o + 1'b1;
  end

  // R5
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |=> rd_ptr_o == $past(rd_ptr_o));
  // R5
  rd_occ_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ptr_s_i - rd_ptr_o) <= PW'(DEPTH));
endmodule

// File: rtl/lockstep_fifo.sv
module lockstep_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8
) (
  input  logic             wr_clk_i,
  input  logic             rd_clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic             full_o,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0]    wr_ptr, rd_ptr, wr_ptr_s, rd_ptr_s;
  logic             push;
  logic [WIDTH-1:0] mem_q [DEPTH];

  fifo_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .rd_ptr_s_i(rd_ptr_s), .wr_ptr_o(wr_ptr), .push_o(push), .full_o(full_o)
  );

  fifo_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i),
    .wr_ptr_s_i(wr_ptr_s), .rd_ptr_o(rd_ptr), .empty_o(empty_o)
  );

  ptr_ring #(.W(PW)) u_w2r (
    .src_clk_i(wr_clk_i), .dst_clk_i(rd_clk_i), .rst_ni(rst_ni),
    .d_i(wr_ptr), .q_o(wr_ptr_s)
  );

  ptr_ring #(.W(PW)) u_r2w (
    .src_clk_i(rd_clk_i), .dst_clk_i(wr_clk_i), .rst_ni(rst_ni),
    .d_i(rd_ptr), .q_o(rd_ptr_s)
  );

  // storage: written in write domain, read asynchronously (first word fall through)
  always_ff @(posedge wr_clk_i) begin
    if (push) mem_q[wr_ptr[AW-1:0]] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_ptr[AW-1:0]];

  // R1
  reset_flags_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> empty_o);
endmodule

// File: tb/lockstep_fifo_tb_top.sv
module lockstep_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  // each entry: {writes, reads}
  localparam logic [15:0] VEC [8] = '{
    {8'd5,  8'd0}, {8'd0,  8'd3}, {8'd16, 8'd0}, {8'd0, 8'd16},
    {8'd0,  8'd2}, {8'd3,  8'd3}, {8'd9,  8'd4}, {8'd0, 8'd9}
  };

  logic wr_clk = 0, rd_clk = 0, rst_ni = 0;
  logic wr_en = 0, rd_en = 0;
  logic [WIDTH-1:0] wr_data = '0;
  logic full_o, empty_o;
  logic [WIDTH-1:0] rd_data_o;

  int checks = 0, errors = 0;
  logic [WIDTH-1:0] q [256];
  int head = 0, tail = 0;
  logic [WIDTH-1:0] wdat = 8'h10;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  initial begin
    #(CLK_PERIOD/4);
    forever #(CLK_PERIOD/2) rd_clk = ~rd_clk;
  end

  lockstep_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .full_o(full_o),
    .rd_en_i(rd_en), .rd_data_o(rd_data_o), .empty_o(empty_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cnt();
    return tail - head;
  endfunction

  task automatic do_writes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      if (!full_o) begin q[tail[7:0]] = wdat; tail++; end
      wr_en = 1; wr_data = wdat; wdat++;
    end
    @(negedge wr_clk); wr_en = 0;
  endtask

  task automatic do_reads(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      if (!empty_o) begin
        // R3 R6: data order and fall-through
        chk(rd_data_o == q[head[7:0]], "R3", int'(rd_data_o), int'(q[head[7:0]]));
        head++;
      end
      rd_en = 1;
    end
    @(negedge rd_clk); rd_en = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge wr_clk);
    @(negedge rd_clk);
  endtask

  task automatic chk_flags(input string req);
    chk(full_o == (cnt() == DEPTH), req, int'(full_o), int'(cnt() == DEPTH));
    chk(empty_o == (cnt() == 0), req, int'(empty_o), int'(cnt() == 0));
    if (!empty_o)
      chk(rd_data_o == q[head[7:0]], "R6", int'(rd_data_o), int'(q[head[7:0]]));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    #(CLK_PERIOD * 3 + 3);
    // R1: flags during reset
    chk(empty_o == 1'b1, "R1", int'(empty_o), 1);
    chk(full_o == 1'b0, "R1", int'(full_o), 0);
    rst_ni = 1;
    settle();
    chk(empty_o == 1'b1, "R1", int'(empty_o), 1);
    chk(full_o == 1'b0, "R1", int'(full_o), 0);

    // table walk (R2 R3 R4 R5)
    for (int v = 0; v < 8; v++) begin
      do_writes(int'(VEC[v][15:8]));
      do_reads(int'(VEC[v][7:0]));
      settle();
      chk_flags("R2");
    end

    // R4: overflow into empty FIFO
    chk(cnt() == 0, "R4", cnt(), 0);
    do_writes(20);
    chk(cnt() == DEPTH, "R4", cnt(), DEPTH);
    chk(full_o == 1'b1, "R4", int'(full_o), 1);
    do_reads(DEPTH);
    // R7: empty right after last pop
    chk(empty_o == 1'b1, "R7", int'(empty_o), 1);
    settle();
    chk(empty_o == 1'b1, "R4", int'(empty_o), 1);

    // R5: reads on empty ignored
    do_reads(3);
    settle();
    chk(empty_o == 1'b1, "R5", int'(empty_o), 1);
    do_writes(2);
    settle();
    chk(rd_data_o == q[head[7:0]], "R5", int'(rd_data_o), int'(q[head[7:0]]));
    do_reads(2);
    settle();
    chk(empty_o == 1'b1, "R5", int'(empty_o), 1);

    // R8: empty release latency
    @(negedge wr_clk); wr_en = 1; wr_data = wdat; q[tail[7:0]] = wdat; tail++; wdat++;
    @(negedge wr_clk); wr_en = 0;
    n = 0;
    while (empty_o && n < 8) begin @(negedge rd_clk); n++; end
    chk(n <= 4, "R8", n, 4);
    chk(rd_data_o == q[head[7:0]], "R6", int'(rd_data_o), int'(q[head[7:0]]));

    // R7: full rises right after DEPTH-th word
    do_writes(DEPTH - 2);
    @(negedge wr_clk); wr_en = 1; wr_data = wdat; q[tail[7:0]] = wdat; tail++; wdat++;
    chk(full_o == 1'b0, "R7", int'(full_o), 0);
    @(negedge wr_clk); wr_en = 0;
    chk(full_o == 1'b1, "R7", int'(full_o), 1);

    // R8: full release latency
    @(negedge rd_clk); rd_en = 1;
    chk(rd_data_o == q[head[7:0]], "R3", int'(rd_data_o), int'(q[head[7:0]]));
    head++;
    @(negedge rd_clk); rd_en = 0;
    n = 0;
    while (full_o && n < 8) begin @(negedge wr_clk); n++; end
    chk(n <= 4, "R8", n, 4);
    do_reads(DEPTH);
    settle();
    chk_flags("R8");

    // R9: concurrent traffic
    fork
      do_writes(60);
      do_reads(60);
    join
    do_reads(DEPTH + 4);
    settle();
    chk(cnt() == 0, "R9", cnt(), 0);
    chk_flags("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule